// File: doc/BRIEF.md
# Exception Vector and Fault-State Unit

This block sits beside the pipeline of a 32-bit RISC core. It takes fault requests, works out where the handler starts and records the fault in the system-control registers. A request lasts one cycle. It carries a fault kind, the faulting virtual address, an address-space identifier, a virtual page number, a load/store flag and a coprocessor number. The block keeps six registers: status, cause, exception base, bad virtual address, translation entry-high and context.

The handler address is a vector base plus an offset. The base is either the exception base register or a fixed boot-time address, chosen by the status boot-vector bit. The offset depends on the fault kind and on the live status and cause bits. For every accepted fault the block does the following. It presents the new program counter on a one-cycle redirect strobe and sets the status exception-level bit. It writes the exception code into the cause register. Depending on the kind, it also fills in the bad address, the translation entry-high fields, the context page field or the coprocessor field. Software reads and writes the registers through a small synchronous index/data port.

Top module: `fault_vector_unit`

## Requirements
- R1: After reset the registers hold these values: status 0x0040_0000 (boot-vector bit 22 set, exception-level bit 1 clear), exception base 0x8000_0000, and cause, bad address, entry-high and context all zero. The redirect strobe is low.
- R2: The vector base is 0xBFC0_0200 while status bit 22 is set, and the exception base register while it is clear.
- R3: A fault request presented in cycle t gives redirectValid high in cycle t+1, for that cycle only, with redirectPc = base + offset. The offset is 0x180 unless R4 or R5 says otherwise. The base and offset are taken from the register values before the fault's own update.
- R4: A translation refill (kind 2) uses offset 0x000 while status bit 1 is clear and 0x180 while it is set.
- R5: An interrupt (kind 0) uses offset 0x200 while cause bit 23 is set and 0x180 otherwise.
- R6: The exception code is written to cause bits [6:2]. The fault kinds and their codes are: 0 interrupt→0, 1 translation-modified→1, 5 syscall→8, 6 breakpoint→9, 7 reserved instruction→10, 8 coprocessor unusable→11, 9 overflow→12, 10 trap→13, 11 machine check→24, 12 thread→25, 13 instruction bus error→6, 14 data bus error→7, 15 watch→23.
- R7: Address error (kind 4) reports 5 for a store and 4 for a load. Refill (kind 2) and translation-invalid (kind 3) report 3 for a store and 2 for a load. Translation-modified always reports 1, whatever the store flag.
- R8: Address-error and translation faults (kinds 1 to 4) write the faulting address to the bad-address register. Other kinds leave that register unchanged.
- R9: On a translation fault (kinds 1 to 3), entry-high takes the identifier in bits [7:0], vpn>>2 in bits [31:13] and vpn&3 in bits [12:11], and keeps bits [10:8]. The context register takes vpn>>2 in bits [22:4] and keeps its other bits.
- R10: A coprocessor-unusable fault writes the requesting coprocessor number into cause bits [29:28].
- R11: Every accepted fault sets status bit 1 and keeps every other status bit. It also keeps cause bit 23.
- R12: When several request ports are valid in the same cycle, only the lowest-numbered port is accepted. The others are dropped.
- R13: A software write in the same cycle as an accepted fault is discarded.
- R14: The register indices are 0 status, 1 cause, 2 exception base, 3 bad address, 4 entry-high and 5 context. regRdData shows the register selected by regIdx one cycle later. Indices 6 and 7 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NREQ | One-cycle fault request per port |
| reqKind | input | NREQ x 4 | Fault kind per port |
| reqStore | input | NREQ | Store (1) or load (0) access |
| reqVaddr | input | NREQ x 32 | Faulting virtual address |
| reqAsid | input | NREQ x ASID_W | Address-space identifier |
| reqVpn | input | NREQ x VPN_W | Faulting virtual page number |
| reqCopId | input | NREQ x 2 | Requesting coprocessor number |
| regIdx | input | 3 | Register index for read and write |
| regWrData | input | 32 | Software write data |
| regWrEn | input | 1 | Software write enable |
| regRdData | output | 32 | Registered read data |
| redirectValid | output | 1 | New-PC strobe |
| redirectPc | output | 32 | Handler entry address |

## Verification
On every cycle the assertions check the timing of the redirect strobe against the requests. They also check that the exception-level bit is set after each accepted fault, and that cause bit 23 survives a fault even when software writes in the same cycle. The vector arithmetic is left to the bench scenarios: base selection, the refill and interrupt offsets, the per-kind exception codes, the split of the page number across entry-high and context, port arbitration and the dropped software write. Each of these is observed through the redirect outputs and register reads.

// File: rtl/fvu_pkg.sv
package fvu_pkg;

  localparam int REG_IDX_W = 3;

  typedef enum logic [3:0] {
    FK_INTR         = 4'd0,
    FK_TLB_MOD      = 4'd1,
    FK_TLB_REFILL   = 4'd2,
    FK_TLB_INVALID  = 4'd3,
    FK_ADDR_ERR     = 4'd4,
    FK_SYSCALL      = 4'd5,
    FK_BREAK        = 4'd6,
    FK_RESERVED     = 4'd7,
    FK_COP_UNUSABLE = 4'd8,
    FK_OVERFLOW     = 4'd9,
    FK_TRAP         = 4'd10,
    FK_MCHECK       = 4'd11,
    FK_THREAD       = 4'd12,
    FK_IBUS_ERR     = 4'd13,
    FK_DBUS_ERR     = 4'd14,
    FK_WATCH        = 4'd15
  } fault_kind_e;

  // Register map indices
  localparam logic [REG_IDX_W-1:0] RI_STATUS  = 3'd0;
  localparam logic [REG_IDX_W-1:0] RI_CAUSE   = 3'd1;
  localparam logic [REG_IDX_W-1:0] RI_EBASE   = 3'd2;
  localparam logic [REG_IDX_W-1:0] RI_BADVA   = 3'd3;
  localparam logic [REG_IDX_W-1:0] RI_ENTRYHI = 3'd4;
  localparam logic [REG_IDX_W-1:0] RI_CONTEXT = 3'd5;

  // Field positions decoded by neighbouring logic
  localparam int ST_BEV_BIT  = 22;
  localparam int ST_EXL_BIT  = 1;
  localparam int CA_IV_BIT   = 23;
  localparam int CA_CE_LSB   = 28;
  localparam int CA_EXC_LSB  = 2;
  localparam int CTX_VPN_LSB = 4;

  localparam logic [31:0] BOOT_BASE     = 32'hBFC0_0200;
  localparam logic [31:0] STATUS_RESET  = 32'h0040_0000;
  localparam logic [31:0] EBASE_RESET   = 32'h8000_0000;
  localparam logic [11:0] OFS_GENERAL   = 12'h180;
  localparam logic [11:0] OFS_INTR_VEC  = 12'h200;
  localparam logic [11:0] OFS_REFILL    = 12'h000;

  typedef struct packed {
    logic        take;
    logic [4:0]  excCode;
    logic        wrBadVa;
    logic        wrTlb;
    logic        wrCe;
    logic [11:0] vecOffset;
  } fvu_ctl_t;

endpackage

// File: rtl/fvu_ctrl.sv
module fvu_ctrl
  import fvu_pkg::*;
#(
  parameter int NREQ   = 2,
  parameter int VPN_W  = 21,
  parameter int ASID_W = 8
) (
  input  logic [NREQ-1:0]             reqValid,
  input  logic [NREQ-1:0][3:0]        reqKind,
  input  logic [NREQ-1:0]             reqStore,
  input  logic [NREQ-1:0][31:0]       reqVaddr,
  input  logic [NREQ-1:0][ASID_W-1:0] reqAsid,
  input  logic [NREQ-1:0][VPN_W-1:0]  reqVpn,
  input  logic [NREQ-1:0][1:0]        reqCopId,
  input  logic                        exlQ,
  input  logic                        ivQ,
  output fvu_ctl_t                    ctl,
  output logic [31:0]                 selVaddr,
  output logic [ASID_W-1:0]           selAsid,
  output logic [VPN_W-1:0]            selVpn,
  output logic [1:0]                  selCopId
);

  localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [IDX_W-1:0] selIdx;
  fault_kind_e      selKind;
  logic             selStore;

  // Lowest-numbered valid port wins
  always_comb begin
    selIdx = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (reqValid[i]) selIdx = IDX_W'(i);
    end
  end

  assign selKind  = fault_kind_e'(reqKind[selIdx]);
  assign selStore = reqStore[selIdx];
  assign selVaddr = reqVaddr[selIdx];
  assign selAsid  = reqAsid[selIdx];
  assign selVpn   = reqVpn[selIdx];
  assign selCopId = reqCopId[selIdx];

  always_comb begin
    ctl           = '0;
    ctl.take      = |reqValid;
    ctl.vecOffset = OFS_GENERAL;
    unique case (selKind)
      FK_INTR: begin
        ctl.excCode   = 5'd0;
        ctl.vecOffset = ivQ ? OFS_INTR_VEC : OFS_GENERAL;
      end
      FK_TLB_MOD: begin
        ctl.excCode = 5'd1;
        ctl.wrBadVa = 1'b1;
        ctl.wrTlb   = 1'b1;
      end
      FK_TLB_REFILL: begin
        ctl.excCode   = selStore ? 5'd3 : 5'd2;
        ctl.wrBadVa   = 1'b1;
        ctl.wrTlb     = 1'b1;
        ctl.vecOffset = exlQ ? OFS_GENERAL : OFS_REFILL;
      end
      FK_TLB_INVALID: begin
        ctl.excCode = selStore ? 5'd3 : 5'd2;
        ctl.wrBadVa = 1'b1;
        ctl.wrTlb   = 1'b1;
      end
      FK_ADDR_ERR: begin
        ctl.excCode = selStore ? 5'd5 : 5'd4;
        ctl.wrBadVa = 1'b1;
      end
      FK_SYSCALL:      ctl.excCode = 5'd8;
      FK_BREAK:        ctl.excCode = 5'd9;
      FK_RESERVED:     ctl.excCode = 5'd10;
      FK_COP_UNUSABLE: begin
        ctl.excCode = 5'd11;
        ctl.wrCe    = 1'b1;
      end
      FK_OVERFLOW:     ctl.excCode = 5'd12;
      FK_TRAP:         ctl.excCode = 5'd13;
      FK_MCHECK:       ctl.excCode = 5'd24;
      FK_THREAD:       ctl.excCode = 5'd25;
      FK_IBUS_ERR:     ctl.excCode = 5'd6;
      FK_DBUS_ERR:     ctl.excCode = 5'd7;
      FK_WATCH:        ctl.excCode = 5'd23;
      default:         ctl.excCode = 5'd0;
    endcase
  end

endmodule

// File: rtl/fvu_dpath.sv
module fvu_dpath
  import fvu_pkg::*;
#(
  parameter int VPN_W  = 21,
  parameter int ASID_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fvu_ctl_t             ctl,
  input  logic [31:0]          selVaddr,
  input  logic [ASID_W-1:0]    selAsid,
  input  logic [VPN_W-1:0]     selVpn,
  input  logic [1:0]           selCopId,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic [31:0]          regWrData,
  input  logic                 regWrEn,
  output logic [31:0]          regRdData,
  output logic                 redirectValid,
  output logic [31:0]          redirectPc,
  output logic                 exlQ,
  output logic                 ivQ
);

  localparam int VPN2_W    = VPN_W - 2;
  localparam int EHI_V_LSB = 32 - VPN2_W;
  localparam int EHI_X_LSB = EHI_V_LSB - 2;

  logic [31:0] statusQ, causeQ, ebaseQ, badVaQ, entryHiQ, contextQ;
  logic [31:0] vecBase;

  assign exlQ    = statusQ[ST_EXL_BIT];
  assign ivQ     = causeQ[CA_IV_BIT];
  assign vecBase = statusQ[ST_BEV_BIT] ? BOOT_BASE : ebaseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ       <= STATUS_RESET;
      causeQ        <= '0;
      ebaseQ        <= EBASE_RESET;
      badVaQ        <= '0;
      entryHiQ      <= '0;
      contextQ      <= '0;
      redirectValid <= 1'b0;
      redirectPc    <= '0;
    end else begin
      redirectValid <= ctl.take;
      if (ctl.take) begin
        redirectPc                  <= vecBase + {20'd0, ctl.vecOffset};
        statusQ[ST_EXL_BIT]         <= 1'b1;
        causeQ[CA_EXC_LSB +: 5]     <= ctl.excCode;
        if (ctl.wrCe) causeQ[CA_CE_LSB +: 2] <= selCopId;
        if (ctl.wrBadVa) badVaQ <= selVaddr;
        if (ctl.wrTlb) begin
          entryHiQ[EHI_V_LSB +: VPN2_W]   <= selVpn[VPN_W-1:2];
          entryHiQ[EHI_X_LSB +: 2]        <= selVpn[1:0];
          entryHiQ[ASID_W-1:0]            <= selAsid;
          contextQ[CTX_VPN_LSB +: VPN2_W] <= selVpn[VPN_W-1:2];
        end
      end else if (regWrEn) begin
        case (regIdx)
          RI_STATUS:  statusQ  <= regWrData;
          RI_CAUSE:   causeQ   <= regWrData;
          RI_EBASE:   ebaseQ   <= regWrData;
          RI_BADVA:   badVaQ   <= regWrData;
          RI_ENTRYHI: entryHiQ <= regWrData;
          RI_CONTEXT: contextQ <= regWrData;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
    end else begin
      case (regIdx)
        RI_STATUS:  regRdData <= statusQ;
        RI_CAUSE:   regRdData <= causeQ;
        RI_EBASE:   regRdData <= ebaseQ;
        RI_BADVA:   regRdData <= badVaQ;
        RI_ENTRYHI: regRdData <= entryHiQ;
        RI_CONTEXT: regRdData <= contextQ;
        default:    regRdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/fault_vector_unit.sv
module fault_vector_unit
  import fvu_pkg::*;
#(
  parameter int NREQ   = 2,
  parameter int VPN_W  = 21,
  parameter int ASID_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NREQ-1:0]             reqValid,
  input  logic [NREQ-1:0][3:0]        reqKind,
  input  logic [NREQ-1:0]             reqStore,
  input  logic [NREQ-1:0][31:0]       reqVaddr,
  input  logic [NREQ-1:0][ASID_W-1:0] reqAsid,
  input  logic [NREQ-1:0][VPN_W-1:0]  reqVpn,
  input  logic [NREQ-1:0][1:0]        reqCopId,
  input  logic [REG_IDX_W-1:0]        regIdx,
  input  logic [31:0]                 regWrData,
  input  logic                        regWrEn,
  output logic [31:0]                 regRdData,
  output logic                        redirectValid,
  output logic [31:0]                 redirectPc
);

  fvu_ctl_t          ctl;
  logic [31:0]       selVaddr;
  logic [ASID_W-1:0] selAsid;
  logic [VPN_W-1:0]  selVpn;
  logic [1:0]        selCopId;
  logic              exlQ;
  logic              ivQ;

  fvu_ctrl #(.NREQ(NREQ), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_ctrl (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqStore (reqStore),
    .reqVaddr (reqVaddr),
    .reqAsid  (reqAsid),
    .reqVpn   (reqVpn),
    .reqCopId (reqCopId),
    .exlQ     (exlQ),
    .ivQ      (ivQ),
    .ctl      (ctl),
    .selVaddr (selVaddr),
    .selAsid  (selAsid),
    .selVpn   (selVpn),
    .selCopId (selCopId)
  );

  fvu_dpath #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .selVaddr      (selVaddr),
    .selAsid       (selAsid),
    .selVpn        (selVpn),
    .selCopId      (selCopId),
    .regIdx        (regIdx),
    .regWrData     (regWrData),
    .regWrEn       (regWrEn),
    .regRdData     (regRdData),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .exlQ          (exlQ),
    .ivQ           (ivQ)
  );

endmodule

// File: rtl/fvu_checker.sv
module fvu_checker #(
  parameter int NREQ = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic [NREQ-1:0] reqValid,
  input logic            redirectValid,
  input logic            exlQ,
  input logic            ivQ
);

  // R3: every request produces a redirect on the following cycle
  assert_redirect_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |=> redirectValid);

  // R3: no redirect without a request one cycle earlier
  assert_redirect_caused_R3: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(|reqValid));

  // R11: exception level is set after an accepted fault
  assert_exl_set_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |=> exlQ);

  // R13: a software write cannot change cause bit 23 under a fault
  assert_iv_held_R13: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |=> $stable(ivQ));

endmodule

bind fault_vector_unit fvu_checker #(.NREQ(NREQ)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .redirectValid (redirectValid),
  .exlQ          (exlQ),
  .ivQ           (ivQ)
);

// File: tb/sim_fault_vector_unit.sv
module sim_fault_vector_unit;

  localparam int NREQ = 2;
  localparam int VPN_W = 21;
  localparam int ASID_W = 8;

  localparam logic [3:0] K_INTR = 4'd0, K_MOD = 4'd1, K_REFILL = 4'd2, K_INVAL = 4'd3,
                         K_ADDR = 4'd4, K_SYS = 4'd5, K_COP = 4'd8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NREQ-1:0]             reqValid = '0;
  logic [NREQ-1:0][3:0]        reqKind = '0;
  logic [NREQ-1:0]             reqStore = '0;
  logic [NREQ-1:0][31:0]       reqVaddr = '0;
  logic [NREQ-1:0][ASID_W-1:0] reqAsid = '0;
  logic [NREQ-1:0][VPN_W-1:0]  reqVpn = '0;
  logic [NREQ-1:0][1:0]        reqCopId = '0;
  logic [2:0]  regIdx = '0;
  logic [31:0] regWrData = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regRdData;
  logic        redirectValid;
  logic [31:0] redirectPc;

  int nTests = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  fault_vector_unit #(.NREQ(NREQ), .VPN_W(VPN_W), .ASID_W(ASID_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqStore(reqStore), .reqVaddr(reqVaddr), .reqAsid(reqAsid),
    .reqVpn(reqVpn), .reqCopId(reqCopId), .regIdx(regIdx),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdData(regRdData),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdReg(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk);
    regIdx = idx;
    @(negedge clk);
    val = regRdData;
  endtask

  task automatic wrReg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    regIdx = idx; regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic armReq(input int p, input logic [3:0] k, input logic [31:0] va,
                        input logic [7:0] asid, input logic [20:0] vpn,
                        input logic st, input logic [1:0] cop);
    reqValid[p] = 1'b1; reqKind[p] = k; reqVaddr[p] = va; reqAsid[p] = asid;
    reqVpn[p] = vpn; reqStore[p] = st; reqCopId[p] = cop;
  endtask

  task automatic pulse(output logic [31:0] pc, output logic v);
    @(negedge clk);
    pc = redirectPc; v = redirectValid;
    reqValid = '0; regWrEn = 1'b0;
  endtask

  task automatic fire1(input logic [3:0] k, input logic [31:0] va, input logic [7:0] asid,
                       input logic [20:0] vpn, input logic st, input logic [1:0] cop,
                       input string req, input logic [31:0] expPc);
    logic [31:0] pc; logic v;
    @(negedge clk);
    armReq(0, k, va, asid, vpn, st, cop);
    pulse(pc, v);
    chk({req, " redirect valid"}, {31'd0, v}, 32'd1);
    chk({req, " redirect pc"}, pc, expPc);
  endtask

  task automatic testReset();
    logic [31:0] r;
    chk("R1 redirect idle", {31'd0, redirectValid}, 32'd0);
    rdReg(3'd0, r); chk("R1 status", r, 32'h0040_0000);
    rdReg(3'd1, r); chk("R1 cause", r, 32'h0);
    rdReg(3'd2, r); chk("R1 ebase", r, 32'h8000_0000);
    rdReg(3'd3, r); chk("R1 badva", r, 32'h0);
    rdReg(3'd4, r); chk("R1 entryhi", r, 32'h0);
    rdReg(3'd5, r); chk("R1 context", r, 32'h0);
  endtask

  task automatic testRegPort();
    logic [31:0] r;
    wrReg(3'd3, 32'h1111_2222);
    rdReg(3'd3, r); chk("R14 badva readback", r, 32'h1111_2222);
    wrReg(3'd7, 32'hFFFF_FFFF);
    rdReg(3'd7, r); chk("R14 unused index", r, 32'h0);
    rdReg(3'd6, r); chk("R14 unused index 6", r, 32'h0);
  endtask

  task automatic testBootVector();
    logic [31:0] r;
    fire1(K_SYS, 32'h0, 8'h0, 21'h0, 1'b0, 2'd0, "R2 R3 boot base", 32'hBFC0_0380);
    @(negedge clk);
    chk("R3 single-cycle strobe", {31'd0, redirectValid}, 32'd0);
    rdReg(3'd0, r); chk("R11 exl set, bev kept", r, 32'h0040_0002);
    rdReg(3'd1, r); chk("R6 syscall code", r, 32'd8 << 2);
  endtask

  task automatic testAddrErr();
    logic [31:0] r;
    wrReg(3'd0, 32'h0); wrReg(3'd2, 32'h8000_1000);
    fire1(K_ADDR, 32'h1234_5679, 8'h0, 21'h0, 1'b1, 2'd0, "R2 ebase vector", 32'h8000_1180);
    rdReg(3'd1, r); chk("R7 addr store code", r, 32'd5 << 2);
    rdReg(3'd3, r); chk("R8 badva addr err", r, 32'h1234_5679);
    wrReg(3'd0, 32'h0);
    fire1(K_ADDR, 32'h0000_BEEF, 8'h0, 21'h0, 1'b0, 2'd0, "R3 general offset", 32'h8000_1180);
    rdReg(3'd1, r); chk("R7 addr load code", r, 32'd4 << 2);
  endtask

  task automatic testRefill();
    logic [31:0] r;
    logic [20:0] vpnA;
    vpnA = 21'h1ABCD;
    wrReg(3'd0, 32'h0); wrReg(3'd4, 32'h0000_0700); wrReg(3'd5, 32'hFF80_0000);
    fire1(K_REFILL, 32'h3579_A000, 8'h5A, vpnA, 1'b1, 2'd0, "R4 refill exl clear", 32'h8000_1000);
    rdReg(3'd1, r); chk("R7 refill store code", r, 32'd3 << 2);
    rdReg(3'd3, r); chk("R8 badva refill", r, 32'h3579_A000);
    rdReg(3'd4, r);
    chk("R9 entryhi fields", r, ({13'd0, vpnA[20:2]} << 13) | ({30'd0, vpnA[1:0]} << 11) | 32'h75A);
    rdReg(3'd5, r);
    chk("R9 context field", r, 32'hFF80_0000 | ({13'd0, vpnA[20:2]} << 4));
    fire1(K_REFILL, 32'h0000_3000, 8'h01, 21'h3, 1'b0, 2'd0, "R4 refill exl set", 32'h8000_1180);
    rdReg(3'd1, r); chk("R7 refill load code", r, 32'd2 << 2);
    rdReg(3'd4, r); chk("R9 entryhi second", r, (32'd3 << 11) | 32'h701);
  endtask

  task automatic testOtherTlb();
    logic [31:0] r;
    wrReg(3'd0, 32'h0);
    fire1(K_INVAL, 32'h0000_4000, 8'h02, 21'h4, 1'b0, 2'd0, "R4 invalid general", 32'h8000_1180);
    rdReg(3'd1, r); chk("R7 invalid load code", r, 32'd2 << 2);
    fire1(K_MOD, 32'h0000_5000, 8'h03, 21'h5, 1'b1, 2'd0, "R3 mod", 32'h8000_1180);
    rdReg(3'd1, r); chk("R7 modified code", r, 32'd1 << 2);
    rdReg(3'd3, r); chk("R8 badva mod", r, 32'h0000_5000);
  endtask

  task automatic testIntr();
    logic [31:0] r;
    wrReg(3'd0, 32'h0); wrReg(3'd1, 32'h0); wrReg(3'd3, 32'hAAAA_5555);
    fire1(K_INTR, 32'h1234_0000, 8'h0, 21'h0, 1'b0, 2'd0, "R5 intr iv clear", 32'h8000_1180);
    rdReg(3'd3, r); chk("R8 badva untouched", r, 32'hAAAA_5555);
    wrReg(3'd0, 32'h0); wrReg(3'd1, 32'h0080_0000);
    fire1(K_INTR, 32'h0, 8'h0, 21'h0, 1'b0, 2'd0, "R5 intr iv set", 32'h8000_1200);
    rdReg(3'd1, r); chk("R11 iv kept, code 0", r, 32'h0080_0000);
  endtask

  task automatic testCop();
    logic [31:0] r;
    wrReg(3'd1, 32'h0);
    fire1(K_COP, 32'h0, 8'h0, 21'h0, 1'b0, 2'd2, "R10 cop", 32'h8000_1180);
    rdReg(3'd1, r); chk("R10 ce field", r, (32'd2 << 28) | (32'd11 << 2));
  endtask

  task automatic testCodes();
    logic [31:0] r;
    logic [3:0] kinds [10];
    logic [4:0] codes [10];
    kinds = '{4'd5, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
    codes = '{5'd8, 5'd9, 5'd10, 5'd12, 5'd13, 5'd24, 5'd25, 5'd6, 5'd7, 5'd23};
    wrReg(3'd1, 32'h0);
    for (int i = 0; i < 10; i++) begin
      fire1(kinds[i], 32'h0, 8'h0, 21'h0, 1'b1, 2'd0, "R6 kind", 32'h8000_1180);
      rdReg(3'd1, r); chk("R6 exception code", r, {27'd0, codes[i]} << 2);
    end
  endtask

  task automatic testArb();
    logic [31:0] r, pc;
    logic v;
    @(negedge clk);
    armReq(0, K_ADDR, 32'hA0A0_A0A0, 8'h0, 21'h0, 1'b0, 2'd0);
    armReq(1, K_ADDR, 32'hB0B0_B0B0, 8'h0, 21'h0, 1'b1, 2'd0);
    pulse(pc, v);
    chk("R12 one redirect", {31'd0, v}, 32'd1);
    @(negedge clk);
    chk("R12 no second redirect", {31'd0, redirectValid}, 32'd0);
    rdReg(3'd3, r); chk("R12 port0 wins badva", r, 32'hA0A0_A0A0);
    rdReg(3'd1, r); chk("R12 port0 code", r, 32'd4 << 2);
    @(negedge clk);
    armReq(1, K_ADDR, 32'hB0B0_B0B0, 8'h0, 21'h0, 1'b1, 2'd0);
    pulse(pc, v);
    chk("R12 port1 alone", {31'd0, v}, 32'd1);
    rdReg(3'd3, r); chk("R12 port1 badva", r, 32'hB0B0_B0B0);
  endtask

  task automatic testWriteConflict();
    logic [31:0] r, pc;
    logic v;
    @(negedge clk);
    armReq(0, K_SYS, 32'h0, 8'h0, 21'h0, 1'b0, 2'd0);
    regIdx = 3'd2; regWrData = 32'h9000_0000; regWrEn = 1'b1;
    pulse(pc, v);
    rdReg(3'd2, r); chk("R13 ebase write dropped", r, 32'h8000_1000);
    wrReg(3'd0, 32'h0);
    @(negedge clk);
    armReq(0, K_SYS, 32'h0, 8'h0, 21'h0, 1'b0, 2'd0);
    regIdx = 3'd0; regWrData = 32'h0; regWrEn = 1'b1;
    pulse(pc, v);
    rdReg(3'd0, r); chk("R13 status write dropped", r, 32'h0000_0002);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegPort();
    testBootVector();
    testAddrErr();
    testRefill();
    testOtherTlb();
    testIntr();
    testCop();
    testCodes();
    testArb();
    testWriteConflict();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule